// File: doc/BRIEF.md
# Macro Instruction Execution Core

This block runs short programs of 32-bit macro instructions held in an external program memory. After a start pulse it reads the instruction at its program counter and executes it in the same cycle. It runs one instruction per clock until an exit-marked instruction and the instruction after it have run, or until it meets an illegal encoding. Instructions work on eight 32-bit general registers, and register 0 always reads as zero. The available operations are an ALU with a carry/borrow flag, add-immediate, three bitfield forms, a read from the engine register space, and conditional branches. A branch can have a delay slot, or can annul it.

Every executed non-branch instruction presents a result to a separate result-routing block. The result is a value, a destination register and the 3-bit result code taken from bits [6:4]. The routing block answers in the same cycle with a write enable and write data for the destination register. Reads leave through an address port and come back combinationally on a data port.

Top module: `macro_core`

## Requirements
- R1: After reset, busy_o, done_o, err_o and res_valid_o are all low.
- R2: A start pulse while idle clears registers 1 to 7, the carry flag, the pending delay slot, the pending exit and err_o. In the next cycle busy_o is high and pm_addr_o is 0.
- R3: A start pulse while busy_o is high has no effect on the running program.
- R4: Register 0 reads as zero, and writes to it are discarded.
- R5: Operation 0 with function field [21:17] equal to 0, 1, 2 or 3 computes add, add-with-carry, subtract or subtract-with-borrow. Each of these sets the carry flag to the carry out (add forms) or to the borrow, which is 1 when the true result is negative (subtract forms).
- R6: Operation 0 with function 8, 9, 10, 11 or 12 computes xor, or, and, A and not B, or nand. These functions leave the carry flag unchanged.
- R7: Operation 1 yields A plus the sign-extended 18-bit immediate in [31:14]. Operation 5 drives that same sum's low METHOD_W bits on rd_addr_o and yields rd_data_i.
- R8: The bitfield forms use mask (1<<size[26:22])-1, source position [21:17] and destination position [31:27]. Operation 2 replaces the masked field of A at the destination position with B's field from the source position. Operation 3 gives ((A>>B[4:0])&mask)<<dst. Operation 4 gives ((A>>src)&mask)<<B[4:0].
- R9: Operation 7 tests source A [13:11]. When bit 4 is 0 it branches if A is zero; when bit 4 is 1 it branches if A is nonzero. The target is PC plus the immediate, counted in words. A taken branch with bit 5 clear first runs the next instruction as a delay slot. A taken branch with bit 5 set jumps directly. A branch that sits in a delay slot is not taken.
- R10: After an instruction with bit 7 set, exactly one more instruction runs. Then done_o pulses for one cycle while busy_o falls.
- R11: Operation 6, a set bit 3, or an operation-0 function outside {0-3, 8-12} raises err_o. The core then stops with no result and no done pulse.
- R12: res_valid_o is high exactly for executed non-branch, legal instructions. It carries the result, dst [10:8] and result code [6:4]. The destination register takes wb_data_i when wb_we_i is high.
- R13: Exactly one instruction executes per busy cycle, fetched from pm_addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| pm_addr_o | output | PC_W | Program memory word address |
| pm_data_i | input | 32 | Instruction at pm_addr_o, same cycle |
| rd_addr_o | output | METHOD_W | Engine register read address |
| rd_data_i | input | 32 | Engine register read data, same cycle |
| res_valid_o | output | 1 | Result presented this cycle |
| res_op_o | output | 3 | Result routing code |
| res_dst_o | output | 3 | Destination register |
| res_value_o | output | 32 | Result value |
| wb_we_i | input | 1 | Register write enable from routing block |
| wb_data_i | input | 32 | Register write data from routing block |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | One-cycle end-of-program pulse |
| err_o | output | 1 | Illegal instruction seen, held until next start |

## Verification
The bench builds the core with PC_W of 6 and METHOD_W of 12. A 64-word program memory therefore holds a whole random program together with the filler words that follow its exit. Branch targets computed modulo 64 stay inside the array the bench models. The 12-bit read address packs twice into the 32-bit read data, so every read result shows which address produced it.

// File: rtl/macro_pkg.sv
package macro_pkg;
  typedef enum logic [2:0] {
    OP_ALU    = 3'd0,
    OP_ADDI   = 3'd1,
    OP_BF_INS = 3'd2,
    OP_BF_SHI = 3'd3,
    OP_BF_SHR = 3'd4,
    OP_READ   = 3'd5,
    OP_BAD    = 3'd6,
    OP_BRANCH = 3'd7
  } op_e;

  typedef enum logic [4:0] {
    FN_ADD  = 5'd0,
    FN_ADC  = 5'd1,
    FN_SUB  = 5'd2,
    FN_SBB  = 5'd3,
    FN_XOR  = 5'd8,
    FN_OR   = 5'd9,
    FN_AND  = 5'd10,
    FN_ANDN = 5'd11,
    FN_NAND = 5'd12
  } fn_e;

  // imm = {dbit,size,sbit,srcb}; ALU function = sbit; branch nz = res[0], annul = res[1]
  typedef struct packed {
    logic [4:0] dbit;
    logic [4:0] size;
    logic [4:0] sbit;
    logic [2:0] srcb;
    logic [2:0] srca;
    logic [2:0] dst;
    logic       xit;
    logic [2:0] res;
    logic       rsv;
    logic [2:0] op;
  } insn_t;
endpackage

// File: rtl/macro_alu.sv
module macro_alu
  import macro_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [4:0]   fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         upd_o,
  output logic         ok_o
);
  logic [W:0] sum, dif;
  logic       cin_add, cin_sub;

  assign cin_add = c_i & (fn_i == FN_ADC);
  assign cin_sub = c_i & (fn_i == FN_SBB);
  assign sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_add};
  assign dif = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_sub};

  always_comb begin
    res_o = '0;
    c_o   = 1'b0;
    upd_o = 1'b0;
    ok_o  = 1'b1;
    case (fn_i)
      FN_ADD, FN_ADC: begin res_o = sum[W-1:0]; c_o = sum[W]; upd_o = 1'b1; end
      FN_SUB, FN_SBB: begin res_o = dif[W-1:0]; c_o = dif[W]; upd_o = 1'b1; end
      FN_XOR:  res_o = a_i ^ b_i;
      FN_OR:   res_o = a_i | b_i;
      FN_AND:  res_o = a_i & b_i;
      FN_ANDN: res_o = a_i & ~b_i;
      FN_NAND: res_o = ~(a_i & b_i);
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/macro_bitfield.sv
module macro_bitfield
  import macro_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [2:0]    mode_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [SW-1:0] sbit_i,
  input  logic [SW-1:0] size_i,
  input  logic [SW-1:0] dbit_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] mask;
  assign mask = (W'(1) << size_i) - W'(1);

  always_comb begin
    case (mode_i)
      OP_BF_INS: res_o = (a_i & ~(mask << dbit_i)) | (((b_i >> sbit_i) & mask) << dbit_i);
      OP_BF_SHI: res_o = ((a_i >> b_i[SW-1:0]) & mask) << dbit_i;
      default:   res_o = ((a_i >> sbit_i) & mask) << b_i[SW-1:0];
    endcase
  end
endmodule

// File: rtl/macro_regfile.sv
module macro_regfile #(
  parameter int NREG = 8,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] q [1:NREG-1];

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q[i] <= '0;
      else if (clr_i)                           q[i] <= '0;
      else if (we_i && waddr_i == AW'(i))       q[i] <= wdata_i;
    end
  end

  // register 0 is never stored
  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int i = 1; i < NREG; i++) begin
      if (raddr_a_i == AW'(i)) rdata_a_o = q[i];
      if (raddr_b_i == AW'(i)) rdata_b_o = q[i];
    end
  end
endmodule

// File: rtl/macro_core.sv
module macro_core
  import macro_pkg::*;
#(
  parameter int PC_W     = 10,
  parameter int METHOD_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic [PC_W-1:0]     pm_addr_o,
  input  logic [31:0]         pm_data_i,
  output logic [METHOD_W-1:0] rd_addr_o,
  input  logic [31:0]         rd_data_i,
  output logic                res_valid_o,
  output logic [2:0]          res_op_o,
  output logic [2:0]          res_dst_o,
  output logic [31:0]         res_value_o,
  input  logic                wb_we_i,
  input  logic [31:0]         wb_data_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o
);
  localparam int W    = 32;
  localparam int NREG = 8;
  localparam int IMMW = 18;

  logic            busy_q, done_q, err_q, carry_q, dly_q, xit_q;
  logic [PC_W-1:0] pc_q, tgt_q, br_tgt;

  insn_t      ins;
  op_e        op;
  logic [W-1:0] imm, a, b, addsum, alu_res, bf_res;
  logic       alu_c, alu_upd, alu_ok, illegal, is_br, br_taken;

  assign ins = insn_t'(pm_data_i);
  assign op  = op_e'(ins.op);
  assign imm = {{(W-IMMW){ins.dbit[4]}}, ins.dbit, ins.size, ins.sbit, ins.srcb};

  macro_regfile #(.NREG(NREG), .W(W)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!busy_q && start_i),
    .we_i      (res_valid_o && wb_we_i),
    .waddr_i   (ins.dst),
    .wdata_i   (wb_data_i),
    .raddr_a_i (ins.srca),
    .raddr_b_i (ins.srcb),
    .rdata_a_o (a),
    .rdata_b_o (b)
  );

  macro_alu #(.W(W)) i_alu (
    .fn_i  (ins.sbit),
    .a_i   (a),
    .b_i   (b),
    .c_i   (carry_q),
    .res_o (alu_res),
    .c_o   (alu_c),
    .upd_o (alu_upd),
    .ok_o  (alu_ok)
  );

  macro_bitfield #(.W(W)) i_bitfield (
    .mode_i (ins.op),
    .a_i    (a),
    .b_i    (b),
    .sbit_i (ins.sbit),
    .size_i (ins.size),
    .dbit_i (ins.dbit),
    .res_o  (bf_res)
  );

  assign addsum   = a + imm;
  assign illegal  = ins.rsv || op == OP_BAD || (op == OP_ALU && !alu_ok);
  assign is_br    = op == OP_BRANCH;
  // branches inside a delay slot are not taken
  assign br_taken = is_br && !dly_q && (ins.res[0] ? (|a) : ~(|a));
  assign br_tgt   = pc_q + imm[PC_W-1:0];

  always_comb begin
    case (op)
      OP_ALU:                        res_value_o = alu_res;
      OP_BF_INS, OP_BF_SHI, OP_BF_SHR: res_value_o = bf_res;
      OP_READ:                       res_value_o = rd_data_i;
      default:                       res_value_o = addsum;
    endcase
  end

  assign res_valid_o = busy_q && !illegal && !is_br;
  assign res_op_o    = ins.res;
  assign res_dst_o   = ins.dst;
  assign rd_addr_o   = addsum[METHOD_W-1:0];
  assign pm_addr_o   = pc_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      carry_q <= 1'b0;
      dly_q   <= 1'b0;
      xit_q   <= 1'b0;
      pc_q    <= '0;
      tgt_q   <= '0;
    end else if (!busy_q) begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        err_q   <= 1'b0;
        carry_q <= 1'b0;
        dly_q   <= 1'b0;
        xit_q   <= 1'b0;
        pc_q    <= '0;
        tgt_q   <= '0;
      end
    end else if (illegal) begin
      err_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      if (op == OP_ALU && alu_upd) carry_q <= alu_c;
      if (dly_q) begin
        pc_q  <= tgt_q;
        dly_q <= 1'b0;
      end else if (br_taken && ins.res[1]) begin
        pc_q <= br_tgt;
      end else begin
        pc_q <= pc_q + PC_W'(1);
        if (br_taken) begin
          dly_q <= 1'b1;
          tgt_q <= br_tgt;
        end
      end
      if (xit_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (ins.xit) begin
        xit_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/macro_core_chk.sv
module macro_core_chk #(
  parameter int PC_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [PC_W-1:0] pm_addr_o,
  input logic [31:0]     pm_data_i,
  input logic [31:0]     rd_data_i,
  input logic            res_valid_o,
  input logic [31:0]     res_value_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            err_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !err_o));  // R10
  AST_ERR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!busy_o && !done_o));  // R11
  AST_BAD_OP_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pm_data_i[2:0] == 3'd6) |=> (!busy_o && err_o));  // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !res_valid_o);  // R12
  AST_START_PC0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && pm_addr_o == '0 && !err_o));  // R2
  AST_BRANCH_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pm_data_i[2:0] == 3'd7) |-> !res_valid_o);  // R9
  AST_READ_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && pm_data_i[2:0] == 3'd5) |-> res_value_o == rd_data_i);  // R7
endmodule

bind macro_core macro_core_chk #(.PC_W(PC_W)) i_macro_core_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .pm_addr_o   (pm_addr_o),
  .pm_data_i   (pm_data_i),
  .rd_data_i   (rd_data_i),
  .res_valid_o (res_valid_o),
  .res_value_o (res_value_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/test_macro_core.sv
`timescale 1ns/1ps
module test_macro_core;
  localparam int PC_W = 6;
  localparam int MW   = 12;
  localparam int MEM  = 64;
  localparam int LOGN = 512;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [PC_W-1:0] pm_addr_o;
  logic [31:0] pm_data_i, rd_data_i, res_value_o, wb_data_i;
  logic [MW-1:0] rd_addr_o;
  logic res_valid_o, wb_we_i, busy_o, done_o, err_o;
  logic [2:0] res_op_o, res_dst_o;

  logic [31:0] mem [MEM];

  always #4 clk = ~clk;

  assign pm_data_i = mem[pm_addr_o];
  assign rd_data_i = {8'hA5, rd_addr_o, rd_addr_o};
  assign wb_we_i   = res_valid_o && (res_op_o != 3'd0);
  assign wb_data_i = res_value_o;

  macro_core #(.PC_W(PC_W), .METHOD_W(MW)) i_macro_core (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .pm_addr_o(pm_addr_o), .pm_data_i(pm_data_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .res_valid_o(res_valid_o), .res_op_o(res_op_o), .res_dst_o(res_dst_o),
    .res_value_o(res_value_o), .wb_we_i(wb_we_i), .wb_data_i(wb_data_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  bit wd_hit = 1'b0;

  logic [31:0] got_val [LOGN];
  logic [2:0]  got_dst [LOGN];
  int got_n, busy_cyc;
  bit log_on = 1'b0, done_seen;

  logic [31:0] exp_val [LOGN];
  logic [2:0]  exp_dst [LOGN];
  int exp_n, exp_steps;
  bit exp_err;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      check(1'b0, "R13", "watchdog expired", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (log_on) begin
      if (busy_o) begin
        busy_cyc++;
        if (res_valid_o && got_n < LOGN) begin
          got_val[got_n] = res_value_o;
          got_dst[got_n] = res_dst_o;
          got_n++;
        end
      end
      if (done_o) done_seen = 1'b1;
    end
  end

  // instruction encoders
  function automatic logic [31:0] e_alu(input logic [2:0] res, dst, sa, sb,
                                        input logic [4:0] fn, input logic x);
    return {10'b0, fn, sb, sa, dst, x, res, 1'b0, 3'd0};
  endfunction
  function automatic logic [31:0] e_imm(input logic [2:0] op, res, dst, sa,
                                        input logic [17:0] imm, input logic x);
    return {imm, sa, dst, x, res, 1'b0, op};
  endfunction
  function automatic logic [31:0] e_bf(input logic [2:0] op, res, dst, sa, sb,
                                       input logic [4:0] sbit, size, dbit, input logic x);
    return {dbit, size, sbit, sb, sa, dst, x, res, 1'b0, op};
  endfunction
  function automatic logic [31:0] e_br(input logic [2:0] sa, input logic nz, annul,
                                       input logic [17:0] imm, input logic x);
    return {imm, sa, 3'b0, x, 1'b0, annul, nz, 1'b0, 3'd7};
  endfunction

  function automatic bit fn_ok(input logic [4:0] fn);
    return (fn <= 5'd3) || (fn >= 5'd8 && fn <= 5'd12);
  endfunction

  // returns {update, carry, result}
  function automatic logic [33:0] alu_f(input logic [4:0] fn, input logic [31:0] a, b,
                                        input logic c);
    logic [32:0] t;
    case (fn)
      5'd0: begin t = {1'b0, a} + {1'b0, b};                return {1'b1, t}; end
      5'd1: begin t = {1'b0, a} + {1'b0, b} + {32'd0, c};   return {1'b1, t}; end
      5'd2: begin t = {1'b0, a} - {1'b0, b};                return {1'b1, t}; end
      5'd3: begin t = {1'b0, a} - {1'b0, b} - {32'd0, c};   return {1'b1, t}; end
      5'd8:  return {2'b0, a ^ b};
      5'd9:  return {2'b0, a | b};
      5'd10: return {2'b0, a & b};
      5'd11: return {2'b0, a & ~b};
      default: return {2'b0, ~(a & b)};
    endcase
  endfunction

  task automatic run_model();
    logic [31:0] r [8];
    logic c = 1'b0;
    int pc = 0, dt = 0;
    bit dp = 1'b0, xp = 1'b0;
    for (int i = 0; i < 8; i++) r[i] = '0;
    exp_n = 0; exp_steps = 0; exp_err = 1'b0;
    for (int s = 0; s < 1000; s++) begin
      logic [31:0] ins, a, b, imm, v, m, sum;
      logic [33:0] ar;
      logic [4:0] fn;
      int nx, ndt;
      bit ndp;
      ins = mem[pc];
      exp_steps++;
      a = r[ins[13:11]]; b = r[ins[16:14]];
      imm = {{14{ins[31]}}, ins[31:14]};
      fn = ins[21:17];
      m = (32'd1 << ins[26:22]) - 32'd1;
      sum = a + imm;
      nx = (pc + 1) & 63; ndp = 1'b0; ndt = dt;
      if (ins[3] || ins[2:0] == 3'd6 || (ins[2:0] == 3'd0 && !fn_ok(fn))) begin
        exp_err = 1'b1;
        break;
      end
      if (ins[2:0] == 3'd7) begin
        if (!dp && (ins[4] ? (a != 0) : (a == 0))) begin
          if (ins[5]) nx = (pc + int'(imm)) & 63;
          else begin ndp = 1'b1; ndt = (pc + int'(imm)) & 63; end
        end
      end else begin
        case (ins[2:0])
          3'd0: begin ar = alu_f(fn, a, b, c); v = ar[31:0]; if (ar[33]) c = ar[32]; end
          3'd1: v = sum;
          3'd2: v = (a & ~(m << ins[31:27])) | (((b >> ins[21:17]) & m) << ins[31:27]);
          3'd3: v = ((a >> b[4:0]) & m) << ins[31:27];
          3'd4: v = ((a >> ins[21:17]) & m) << b[4:0];
          default: v = {8'hA5, sum[11:0], sum[11:0]};
        endcase
        if (exp_n < LOGN) begin exp_val[exp_n] = v; exp_dst[exp_n] = ins[10:8]; exp_n++; end
        if (ins[6:4] != 3'd0 && ins[10:8] != 3'd0) r[ins[10:8]] = v;
      end
      if (dp) nx = dt;
      dp = ndp; dt = ndt;
      if (xp) break;
      if (ins[7]) xp = 1'b1;
      pc = nx;
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM; i++) mem[i] = 32'h0000_0080;
  endtask

  task automatic gen_prog(input int n);
    clear_mem();
    for (int pc = 0; pc < n; pc++) begin
      logic [31:0] ins;
      logic [2:0] op;
      int r;
      ins = $urandom;
      r = int'($urandom % 8);
      op = (r == 6) ? 3'd7 : 3'(r);
      if (op == 3'd7 && pc >= n - 1) op = 3'd1;
      ins[2:0] = op;
      ins[3] = 1'b0;
      ins[7] = (pc == n - 1);
      if (op == 3'd0) begin
        int k;
        k = int'($urandom % 9);
        ins[21:17] = (k < 4) ? 5'(k) : 5'(k + 4);
      end
      if (op == 3'd7) ins[31:14] = 18'(1 + int'($urandom % (n - 1 - pc)));
      mem[pc] = ins;
    end
  endtask

  task automatic run_prog(input string req, input bit stray);
    int cnt = 0;
    run_model();
    got_n = 0; busy_cyc = 0; done_seen = 1'b0; log_on = 1'b1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (busy_o && cnt < 2000) begin
      @(negedge clk);
      cnt++;
      start_i = (stray && cnt == 1 && busy_o);
    end
    start_i = 1'b0;
    @(negedge clk);
    log_on = 1'b0;
    begin
      int bad = -1;
      for (int i = 0; i < exp_n && i < got_n; i++)
        if (bad < 0 && (got_val[i] !== exp_val[i] || got_dst[i] !== exp_dst[i])) bad = i;
      if (bad >= 0)
        check(1'b0, req, $sformatf("result %0d", bad), got_val[bad], exp_val[bad]);
      else
        check(got_n == exp_n, req, "result count", got_n, exp_n);
    end
    check(busy_cyc == exp_steps, "R13", "busy cycles", busy_cyc, exp_steps);
    check(err_o == exp_err && done_seen == !exp_err, "R10 R11", "err,done",
          {err_o, done_seen}, {exp_err, !exp_err});
  endtask

  initial begin
    void'($urandom(32'd1357));
    clear_mem();
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !err_o && !res_valid_o, "R1", "reset outputs",
          {busy_o, done_o, err_o, res_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5 carry chain
    clear_mem();
    mem[0] = e_imm(3'd1, 3'd1, 3'd1, 3'd0, 18'h3FFFF, 1'b0);
    mem[1] = e_imm(3'd1, 3'd1, 3'd2, 3'd0, 18'd1, 1'b0);
    mem[2] = e_alu(3'd1, 3'd3, 3'd1, 3'd2, 5'd0, 1'b0);
    mem[3] = e_alu(3'd1, 3'd4, 3'd0, 3'd0, 5'd1, 1'b1);
    run_prog("R5", 1'b0);
    check(got_val[2] == 32'd0 && got_val[3] == 32'd1, "R5", "add carry",
          {got_val[2], got_val[3]}, 64'd1);

    // R5 borrow chain; leaves carry set and r4 nonzero
    clear_mem();
    mem[0] = e_imm(3'd1, 3'd1, 3'd1, 3'd0, 18'd1, 1'b0);
    mem[1] = e_imm(3'd1, 3'd1, 3'd2, 3'd0, 18'd2, 1'b0);
    mem[2] = e_alu(3'd1, 3'd3, 3'd1, 3'd2, 5'd2, 1'b0);
    mem[3] = e_alu(3'd1, 3'd4, 3'd0, 3'd0, 5'd3, 1'b1);
    mem[4] = e_imm(3'd1, 3'd0, 3'd0, 3'd0, 18'd0, 1'b0);
    run_prog("R5", 1'b0);
    check(got_val[3] == 32'hFFFF_FFFF, "R5", "sub borrow", got_val[3], 32'hFFFF_FFFF);

    // R2 start clears registers and carry
    clear_mem();
    mem[0] = e_alu(3'd1, 3'd5, 3'd4, 3'd0, 5'd1, 1'b1);
    run_prog("R2", 1'b0);
    check(got_val[0] == 32'd0, "R2", "r4+carry after start", got_val[0], 0);

    // R8 bitfield forms
    clear_mem();
    mem[0] = e_imm(3'd1, 3'd1, 3'd1, 3'd0, 18'h3FFFF, 1'b0);
    mem[1] = e_imm(3'd1, 3'd1, 3'd2, 3'd0, 18'd5, 1'b0);
    mem[2] = e_bf(3'd2, 3'd1, 3'd3, 3'd1, 3'd2, 5'd0, 5'd3, 5'd4, 1'b0);
    mem[3] = e_bf(3'd3, 3'd1, 3'd5, 3'd1, 3'd2, 5'd0, 5'd4, 5'd8, 1'b0);
    mem[4] = e_bf(3'd4, 3'd1, 3'd6, 3'd2, 3'd2, 5'd0, 5'd3, 5'd0, 1'b1);
    run_prog("R8", 1'b0);
    check(got_val[2] == 32'hFFFF_FFDF, "R8", "insert", got_val[2], 32'hFFFF_FFDF);
    check(got_val[3] == 32'h0000_0F00, "R8", "shift imm", got_val[3], 32'h0000_0F00);
    check(got_val[4] == 32'h0000_00A0, "R8", "shift reg", got_val[4], 32'h0000_00A0);

    // R9 delay slot then annulled branch
    clear_mem();
    mem[0] = e_br(3'd0, 1'b0, 1'b0, 18'd3, 1'b0);
    mem[1] = e_imm(3'd1, 3'd1, 3'd1, 3'd0, 18'd7, 1'b0);
    mem[2] = e_imm(3'd1, 3'd1, 3'd2, 3'd0, 18'd9, 1'b0);
    mem[3] = e_br(3'd0, 1'b0, 1'b1, 18'd2, 1'b0);
    mem[4] = e_imm(3'd1, 3'd1, 3'd3, 3'd0, 18'd11, 1'b0);
    mem[5] = e_imm(3'd1, 3'd1, 3'd4, 3'd0, 18'd13, 1'b1);
    run_prog("R9", 1'b0);
    check(busy_cyc == 5 && got_val[0] == 32'd7 && got_val[1] == 32'd13, "R9",
          "slot and annul", {busy_cyc, got_val[1]}, {32'd5, 32'd13});

    // R9 not taken (nonzero test on r0)
    clear_mem();
    mem[0] = e_br(3'd0, 1'b1, 1'b0, 18'd5, 1'b0);
    mem[1] = e_imm(3'd1, 3'd1, 3'd1, 3'd0, 18'd21, 1'b1);
    run_prog("R9", 1'b0);
    check(busy_cyc == 3 && got_val[0] == 32'd21, "R9", "not taken",
          {busy_cyc, got_val[0]}, {32'd3, 32'd21});

    // R4 writes to r0 discarded
    clear_mem();
    mem[0] = e_imm(3'd1, 3'd1, 3'd0, 3'd0, 18'd5, 1'b0);
    mem[1] = e_imm(3'd1, 3'd1, 3'd1, 3'd0, 18'd0, 1'b1);
    run_prog("R4", 1'b0);
    check(got_val[1] == 32'd0, "R4", "r0 reads zero", got_val[1], 0);

    // R7 read path
    clear_mem();
    mem[0] = e_imm(3'd1, 3'd1, 3'd1, 3'd0, 18'd16, 1'b0);
    mem[1] = e_imm(3'd5, 3'd1, 3'd2, 3'd1, 18'd3, 1'b1);
    run_prog("R7", 1'b0);
    check(got_val[1] == 32'hA501_3013, "R7", "read data", got_val[1], 32'hA501_3013);

    // R11 illegal encodings
    clear_mem();
    mem[0] = e_imm(3'd1, 3'd1, 3'd1, 3'd0, 18'd1, 1'b0);
    mem[1] = e_alu(3'd1, 3'd2, 3'd1, 3'd1, 5'd5, 1'b0);
    run_prog("R11", 1'b0);
    check(err_o && busy_cyc == 2 && got_n == 1, "R11", "bad alu fn",
          {err_o, busy_cyc, got_n}, {1'b1, 32'd2, 32'd1});
    clear_mem();
    mem[0] = e_imm(3'd6, 3'd1, 3'd1, 3'd0, 18'd1, 1'b1);
    run_prog("R11", 1'b0);
    check(err_o && got_n == 0, "R11", "op 6", {err_o, got_n}, {1'b1, 32'd0});
    clear_mem();
    mem[0] = e_imm(3'd1, 3'd1, 3'd1, 3'd0, 18'd1, 1'b1) | 32'h8;
    run_prog("R11", 1'b0);
    check(err_o && got_n == 0, "R11", "bit 3 set", {err_o, got_n}, {1'b1, 32'd0});

    // R3 stray start while busy
    gen_prog(12);
    run_prog("R3", 1'b1);

    // R6 R12 random programs
    for (int k = 0; k < 40; k++) begin
      gen_prog(4 + int'($urandom % 17));
      run_prog("R6 R12", (k % 10) == 3);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule